// File: doc/BRIEF.md
# Reorder Buffer Drain Engine

This block holds the in-flight instruction window of an out-of-order core, together with the architectural register file and program counter. It adds a drain mode that empties the window without taking in new work. While the window is idle, it accepts instructions in program order at its tail. Result writebacks from external multicycle execution units mark entries complete. A drain request then stops fetch and bypasses issue selection and unit latency. From that point the engine deals only with the oldest entry. Each cycle it retires that entry, using the stored result when the entry is already complete, or a single-cycle ALU result computed from the current register file when it is not. A one-cycle completion pulse marks the empty window, after which the register file and program counter can be read as an architectural state.

Every entry carries a marker bit. An observation strobe clears all markers and marks the instruction allocated in the same cycle, if there is one. During a drain, the register file is copied into a snapshot bank at the moment the marked entry reaches the head. At that point every older instruction has retired and the entry itself has not. If no entry is marked, the copy is taken in the completion cycle instead. The snapshot and the fully drained state together give the before and after views of the observed step.

Top module: `rob_drain_engine`

## Requirements
- R1: `alloc_ready` is high only when the window holds fewer than DEPTH entries, no drain is active and `drain_req` is low. An `alloc_valid` that is not accepted changes neither occupancy nor `arch_pc`.
- R2: While draining a non-empty window, exactly one head entry retires per cycle, so N entries drain in N cycles.
- R3: A retiring entry with no writeback result writes `op(rf[src_a], rf[src_b])` into its destination in that same cycle. The `alloc_op` encoding is 0 = add, 1 = subtract, 2 = AND, 3 = XOR, all modulo 2^XLEN.
- R4: A retiring entry that received a writeback while idle writes the stored writeback value, not an ALU result.
- R5: Writebacks and observation strobes presented while a drain is active are ignored. Such entries are recomputed by the ALU.
- R6: `drain_done` is high for exactly one cycle. It is high in the (N+1)-th cycle after the clock edge that samples `drain_req`, where N is the occupancy at that edge, so an empty window completes in the first cycle. `drain_busy` is high from that first cycle through the completion cycle.
- R7: `obs_step` while idle clears every marker and marks the entry allocated in that same cycle. At most one entry is ever marked.
- R8: When the marked entry reaches the head during a drain, the snapshot captures the register file as it stands before that entry retires. `snap_valid` rises on the next cycle.
- R9: If no entry is marked, the snapshot is taken in the completion cycle and equals the final register file. `snap_valid` is cleared when a drain starts.
- R10: `arch_pc` increments by one per accepted allocation and never changes during a drain.
- R11: After reset the window is empty, `arch_pc` is 0, register i holds the value i, `snap_valid`, `drain_busy` and `drain_done` are low, and every snapshot register is 0.
- R12: With ZERO_R0 set, register 0 always reads 0 and retirements that target it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | New instruction offered at the tail |
| alloc_op | input | 2 | ALU operation (0 add, 1 sub, 2 and, 3 xor) |
| alloc_rd | input | RW | Destination register |
| alloc_rs1 | input | RW | First source register |
| alloc_rs2 | input | RW | Second source register |
| alloc_ready | output | 1 | Tail can accept an instruction this cycle |
| obs_step | input | 1 | Observation strobe: clear markers, mark this cycle's allocation |
| wb_valid | input | 1 | Result writeback from an execution unit |
| wb_idx | input | PW | Window slot receiving the writeback |
| wb_data | input | XLEN | Writeback value |
| drain_req | input | 1 | Start a drain |
| drain_busy | output | 1 | Drain in progress |
| drain_done | output | 1 | One-cycle pulse: window empty, drain finished |
| arch_pc | output | PCW | Architectural program counter |
| rd_addr | input | RW | Read address for register file and snapshot |
| rd_data | output | XLEN | Register file value at rd_addr |
| snap_valid | output | 1 | Snapshot of the current drain captured |
| snap_data | output | XLEN | Snapshot value at rd_addr |

## Verification
Allocation, writeback, marker and retirement effects appear at the ports one clock edge after the inputs are sampled. Register reads are combinational, so a retirement becomes visible on `rd_data` right after the edge on which it happens. `drain_done` is due N+1 cycles after the edge that samples `drain_req`, and `snap_valid` follows one cycle after the capture cycle. The bench steps a behavioural queue model on the same edge as the design and compares all outputs 1 ns after every rising edge, which sees each result in the exact cycle it is due. Explicit checks also count drain cycles and read out the register file and the snapshot one address per cycle.

// File: rtl/rob_drain_pkg.sv
package rob_drain_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_AND = 2'd2,
      OP_XOR = 2'd3
   } alu_op_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_DRAIN = 1'b1
   } drain_st_e;

endpackage

// File: rtl/rdr_alu.sv
module rdr_alu
   import rob_drain_pkg::*;
#(
   parameter int W = 16
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   y
);

   always_comb begin
      unique case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_AND:  y = a & b;
         OP_XOR:  y = a ^ b;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/rdr_regfile.sv
module rdr_regfile #(
   parameter int W       = 16,
   parameter int NREG    = 8,
   parameter bit ZERO_R0 = 1'b1,
   localparam int RW     = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [RW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [RW-1:0] ra1,
   output logic [W-1:0]  rd1,
   input  logic [RW-1:0] ra2,
   output logic [W-1:0]  rd2,
   input  logic [RW-1:0] ra3,
   output logic [W-1:0]  rd3,
   input  logic          snap_take,
   output logic [W-1:0]  snap_rd3
);

   logic [W-1:0] rf [NREG];
   logic [W-1:0] sn [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (ZERO_R0 && g == 0) begin : g_zero
         assign rf[g] = '0;
         assign sn[g] = '0;
      end else begin : g_live
         logic [W-1:0] q;
         logic [W-1:0] s;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= W'(g);
               s <= '0;
            end else begin
               if (we && waddr == RW'(g)) q <= wdata;
               if (snap_take)             s <= q;
            end
         end
         assign rf[g] = q;
         assign sn[g] = s;
      end
   end

   assign rd1      = rf[ra1];
   assign rd2      = rf[ra2];
   assign rd3      = rf[ra3];
   assign snap_rd3 = sn[ra3];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !(ZERO_R0 && waddr == '0)) |=> rf[$past(waddr)] == $past(wdata)); // R3

   AST_SNAP_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      snap_take |=> sn[$past(ra3)] == $past(rf[ra3])); // R8

endmodule

// File: rtl/rdr_ctrl.sv
module rdr_ctrl
   import rob_drain_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic drain_req,
   input  logic empty,
   input  logic head_mark,
   output logic busy,
   output logic done,
   output logic start,
   output logic snap_take,
   output logic snap_valid
);

   drain_st_e state_q;
   drain_st_e state_d;

   assign busy      = (state_q == ST_DRAIN);
   assign start     = (state_q == ST_IDLE) && drain_req;
   assign done      = busy && empty;
   assign snap_take = busy && !snap_valid && (empty || head_mark);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (drain_req) state_d = ST_DRAIN;
         ST_DRAIN: if (empty)     state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         snap_valid <= 1'b0;
      end else begin
         state_q <= state_d;
         if (start)          snap_valid <= 1'b0;
         else if (snap_take) snap_valid <= 1'b1;
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6

   AST_SNAP_BY_END: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> snap_valid); // R9

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && !snap_valid)); // R9

endmodule

// File: rtl/rob_drain_engine.sv
module rob_drain_engine
   import rob_drain_pkg::*;
#(
   parameter int XLEN    = 16,
   parameter int NREG    = 8,
   parameter int DEPTH   = 8,
   parameter int PCW     = 16,
   parameter bit ZERO_R0 = 1'b1,
   localparam int RW     = $clog2(NREG),
   localparam int PW     = $clog2(DEPTH),
   localparam int CW     = PW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            alloc_valid,
   input  logic [1:0]      alloc_op,
   input  logic [RW-1:0]   alloc_rd,
   input  logic [RW-1:0]   alloc_rs1,
   input  logic [RW-1:0]   alloc_rs2,
   output logic            alloc_ready,
   input  logic            obs_step,
   input  logic            wb_valid,
   input  logic [PW-1:0]   wb_idx,
   input  logic [XLEN-1:0] wb_data,
   input  logic            drain_req,
   output logic            drain_busy,
   output logic            drain_done,
   output logic [PCW-1:0]  arch_pc,
   input  logic [RW-1:0]   rd_addr,
   output logic [XLEN-1:0] rd_data,
   output logic            snap_valid,
   output logic [XLEN-1:0] snap_data
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least 2");
   end
   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two and at least 2");
   end
   if (XLEN < 1 || PCW < 1) begin : g_bad_width
      $error("XLEN and PCW must be positive");
   end

   logic            busy, start, snap_take;
   logic [PW-1:0]   head_q, tail_q;
   logic [CW-1:0]   occ_q;
   logic [PCW-1:0]  pc_q;

   logic [DEPTH-1:0] ent_vld, ent_done, ent_mark;
   alu_op_e          ent_op  [DEPTH];
   logic [RW-1:0]    ent_rd  [DEPTH];
   logic [RW-1:0]    ent_rs1 [DEPTH];
   logic [RW-1:0]    ent_rs2 [DEPTH];
   logic [XLEN-1:0]  ent_res [DEPTH];

   logic empty, full, alloc_fire, retire_fire, wb_fire, obs_fire, head_mark;
   logic [XLEN-1:0] opa, opb, alu_y, ret_data;

   assign empty       = (occ_q == '0);
   assign full        = (occ_q == CW'(DEPTH));
   assign alloc_ready = !full && !busy && !drain_req;
   assign alloc_fire  = alloc_valid && alloc_ready;
   assign retire_fire = busy && !empty;
   assign wb_fire     = !busy && wb_valid && ent_vld[wb_idx];
   assign obs_fire    = !busy && obs_step;
   assign head_mark   = ent_vld[head_q] && ent_mark[head_q];

   // Head-only single-cycle execute path
   rdr_alu #(.W(XLEN)) u_alu (
      .op (ent_op[head_q]),
      .a  (opa),
      .b  (opb),
      .y  (alu_y)
   );

   assign ret_data = ent_done[head_q] ? ent_res[head_q] : alu_y;

   rdr_regfile #(.W(XLEN), .NREG(NREG), .ZERO_R0(ZERO_R0)) u_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (retire_fire),
      .waddr     (ent_rd[head_q]),
      .wdata     (ret_data),
      .ra1       (ent_rs1[head_q]),
      .rd1       (opa),
      .ra2       (ent_rs2[head_q]),
      .rd2       (opb),
      .ra3       (rd_addr),
      .rd3       (rd_data),
      .snap_take (snap_take),
      .snap_rd3  (snap_data)
   );

   rdr_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .drain_req  (drain_req),
      .empty      (empty),
      .head_mark  (head_mark),
      .busy       (busy),
      .done       (drain_done),
      .start      (start),
      .snap_take  (snap_take),
      .snap_valid (snap_valid)
   );

   // Window entries
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_vld  <= '0;
         ent_done <= '0;
         ent_mark <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            ent_op[i]  <= OP_ADD;
            ent_rd[i]  <= '0;
            ent_rs1[i] <= '0;
            ent_rs2[i] <= '0;
            ent_res[i] <= '0;
         end
      end else begin
         if (obs_fire) ent_mark <= '0;
         if (wb_fire) begin
            ent_done[wb_idx] <= 1'b1;
            ent_res[wb_idx]  <= wb_data;
         end
         if (alloc_fire) begin
            ent_vld[tail_q]  <= 1'b1;
            ent_done[tail_q] <= 1'b0;
            ent_mark[tail_q] <= obs_fire;
            ent_op[tail_q]   <= alu_op_e'(alloc_op);
            ent_rd[tail_q]   <= alloc_rd;
            ent_rs1[tail_q]  <= alloc_rs1;
            ent_rs2[tail_q]  <= alloc_rs2;
         end
         if (retire_fire) begin
            ent_vld[head_q]  <= 1'b0;
            ent_done[head_q] <= 1'b0;
            ent_mark[head_q] <= 1'b0;
         end
      end
   end

   // Pointers, occupancy and program counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         occ_q  <= '0;
         pc_q   <= '0;
      end else begin
         if (retire_fire) head_q <= head_q + 1'b1;
         if (alloc_fire) begin
            tail_q <= tail_q + 1'b1;
            pc_q   <= pc_q + 1'b1;
         end
         if (alloc_fire)       occ_q <= occ_q + 1'b1;
         else if (retire_fire) occ_q <= occ_q - 1'b1;
      end
   end

   assign drain_busy = busy;
   assign arch_pc    = pc_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= CW'(DEPTH)); // R1

   AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(pc_q)); // R10

   AST_ONE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !empty) |=> (occ_q == $past(occ_q) - 1'b1)); // R2

   AST_ONE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ent_mark)); // R7

   AST_DRAIN_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !empty) |=> ($countones(ent_done) <= $past($countones(ent_done)))); // R5

endmodule

// File: tb/rob_drain_engine_bench.sv
module rob_drain_engine_bench;

   localparam int XLEN  = 16;
   localparam int NREG  = 8;
   localparam int DEPTH = 8;
   localparam int PCW   = 16;
   localparam int RW    = 3;
   localparam int PW    = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            alloc_valid = 1'b0;
   logic [1:0]      alloc_op = '0;
   logic [RW-1:0]   alloc_rd = '0, alloc_rs1 = '0, alloc_rs2 = '0;
   logic            alloc_ready;
   logic            obs_step = 1'b0;
   logic            wb_valid = 1'b0;
   logic [PW-1:0]   wb_idx = '0;
   logic [XLEN-1:0] wb_data = '0;
   logic            drain_req = 1'b0;
   logic            drain_busy, drain_done, snap_valid;
   logic [PCW-1:0]  arch_pc;
   logic [RW-1:0]   rd_addr = '0;
   logic [XLEN-1:0] rd_data, snap_data;

   // 125 MHz: 8 ns period
   always #4 clk = ~clk;

   rob_drain_engine u_rob_drain_engine (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_op(alloc_op), .alloc_rd(alloc_rd),
      .alloc_rs1(alloc_rs1), .alloc_rs2(alloc_rs2), .alloc_ready(alloc_ready),
      .obs_step(obs_step), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
      .drain_req(drain_req), .drain_busy(drain_busy), .drain_done(drain_done),
      .arch_pc(arch_pc), .rd_addr(rd_addr), .rd_data(rd_data),
      .snap_valid(snap_valid), .snap_data(snap_data)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   typedef struct {
      int op; int rd; int rs1; int rs2; int res; bit done; bit mark; int slot;
   } ment_t;

   ment_t mq[$];
   int    m_rf   [NREG];
   int    m_snap [NREG];
   int    m_pc, m_tail;
   bit    m_busy, m_snapv;

   function automatic int alu_ref(int op, int a, int b);
      case (op)
         0:       return (a + b) & 16'hFFFF;
         1:       return (a - b) & 16'hFFFF;
         2:       return a & b;
         default: return a ^ b;
      endcase
   endfunction

   function automatic bit m_ready();
      return (mq.size() < DEPTH) && !m_busy && !drain_req;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete();
         for (int i = 0; i < NREG; i++) begin m_rf[i] = i; m_snap[i] = 0; end
         m_pc = 0; m_tail = 0; m_busy = 0; m_snapv = 0;
      end else if (m_busy) begin
         if (mq.size() == 0) begin
            if (!m_snapv) begin m_snap = m_rf; m_snapv = 1; end
            m_busy = 0;
         end else begin
            ment_t e;
            int    v;
            e = mq.pop_front();
            if (e.mark && !m_snapv) begin m_snap = m_rf; m_snapv = 1; end
            v = e.done ? e.res : alu_ref(e.op, m_rf[e.rs1], m_rf[e.rs2]);
            if (e.rd != 0) m_rf[e.rd] = v;
         end
      end else begin
         bit    rdy;
         ment_t n;
         rdy = m_ready();
         if (drain_req) begin m_busy = 1; m_snapv = 0; end
         if (wb_valid)
            foreach (mq[i]) if (mq[i].slot == int'(wb_idx)) begin
               mq[i].done = 1; mq[i].res = int'(wb_data);
            end
         if (obs_step) foreach (mq[i]) mq[i].mark = 0;
         if (alloc_valid && rdy) begin
            n.op = int'(alloc_op); n.rd = int'(alloc_rd);
            n.rs1 = int'(alloc_rs1); n.rs2 = int'(alloc_rs2);
            n.res = 0; n.done = 0; n.mark = obs_step; n.slot = m_tail;
            mq.push_back(n);
            m_tail = (m_tail + 1) % DEPTH;
            m_pc   = (m_pc + 1) & 16'hFFFF;
         end
      end
   end

   // ---------------- per-cycle comparison ----------------
   task automatic compare();
      chk(alloc_ready === m_ready(), "R1", "alloc_ready", int'(alloc_ready), int'(m_ready()));
      chk(drain_busy === m_busy, "R6", "drain_busy", int'(drain_busy), int'(m_busy));
      chk(drain_done === (m_busy && mq.size() == 0), "R6", "drain_done",
          int'(drain_done), int'(m_busy && mq.size() == 0));
      chk(int'(arch_pc) == m_pc, "R10", "arch_pc", int'(arch_pc), m_pc);
      chk(snap_valid === m_snapv, "R8", "snap_valid", int'(snap_valid), int'(m_snapv));
      chk(int'(rd_data) == m_rf[rd_addr], "R3", "rd_data", int'(rd_data), m_rf[rd_addr]);
      chk(int'(snap_data) == m_snap[rd_addr], "R8", "snap_data", int'(snap_data), m_snap[rd_addr]);
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
      compare();
   endtask

   task automatic alloc(input int op, input int rd, input int rs1, input int rs2, input bit obs);
      alloc_valid = 1'b1; alloc_op = 2'(op); alloc_rd = RW'(rd);
      alloc_rs1 = RW'(rs1); alloc_rs2 = RW'(rs2); obs_step = obs;
      cyc();
      alloc_valid = 1'b0; obs_step = 1'b0;
   endtask

   task automatic writeback(input int idx, input int val);
      wb_valid = 1'b1; wb_idx = PW'(idx); wb_data = XLEN'(val);
      cyc();
      wb_valid = 1'b0;
   endtask

   // drain; optionally inject a writeback on the first busy cycle
   task automatic drain(input string tag, input bit inj, input int idx);
      int n, k;
      n = mq.size();
      drain_req = 1'b1;
      cyc();
      drain_req = 1'b0;
      k = 1;
      if (inj) begin wb_valid = 1'b1; wb_idx = PW'(idx); wb_data = 16'hDEAD; end
      while (!drain_done && k < 50) begin
         cyc();
         wb_valid = 1'b0;
         k++;
      end
      chk(k == n + 1, tag, "cycles to drain_done", k, n + 1);
      cyc();
   endtask

   // sweep: 0 rf vs model, 1 snapshot vs model, 2 snapshot vs live rf
   task automatic sweep(input string tag, input int mode);
      for (int r = 0; r < NREG; r++) begin
         rd_addr = RW'(r);
         cyc();
         if (mode == 0) chk(int'(rd_data) == m_rf[r], tag, "register", int'(rd_data), m_rf[r]);
         else if (mode == 1) chk(int'(snap_data) == m_snap[r], tag, "snapshot", int'(snap_data), m_snap[r]);
         else chk(snap_data === rd_data, tag, "snapshot equals final rf", int'(snap_data), int'(rd_data));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11: reset state, checked against literal values
      for (int r = 0; r < NREG; r++) begin
         rd_addr = RW'(r);
         cyc();
         chk(int'(rd_data) == r, "R11", "reset register", int'(rd_data), r);
         chk(int'(snap_data) == 0, "R11", "reset snapshot", int'(snap_data), 0);
      end
      chk(int'(arch_pc) == 0, "R11", "reset pc", int'(arch_pc), 0);
      chk(alloc_ready === 1'b1 && drain_busy === 1'b0 && snap_valid === 1'b0,
          "R11", "reset flags", int'(alloc_ready), 1);

      // dependent chain with one stored writeback (R3, R4)
      alloc(0, 1, 2, 3, 0);
      alloc(1, 4, 1, 5, 0);
      alloc(2, 6, 4, 7, 0);
      alloc(3, 2, 6, 1, 0);
      writeback(1, 16'hBEEF);
      rd_addr = 3'd4;
      drain("R2", 0, 0);
      sweep("R3 R4", 0);

      // marked third of five, writeback injected during drain (R5, R7, R8)
      alloc(0, 3, 1, 2, 0);
      alloc(3, 5, 3, 4, 0);
      alloc(1, 7, 5, 1, 1);
      alloc(0, 1, 7, 7, 0);
      alloc(2, 2, 1, 3, 0);
      drain("R6", 1, mq[3].slot);
      sweep("R7 R8", 1);
      sweep("R5", 0);

      // observation with no allocation: snapshot at completion (R9)
      alloc(0, 6, 6, 6, 1);
      obs_step = 1'b1; cyc(); obs_step = 1'b0;
      alloc(1, 5, 6, 2, 0);
      drain("R9", 0, 0);
      chk(snap_valid === 1'b1, "R9", "snap_valid after drain", int'(snap_valid), 1);
      sweep("R9", 2);

      // empty drain completes in one cycle (R6)
      drain("R6", 0, 0);

      // fill to full, extra request refused, r0 targets discarded (R1, R10, R12)
      for (int i = 0; i < DEPTH; i++) alloc(i % 4, i % 3 == 0 ? 0 : i, (i + 1) % 8, (i + 3) % 8, 0);
      chk(alloc_ready === 1'b0, "R1", "ready when full", int'(alloc_ready), 0);
      begin
         int pc0;
         pc0 = int'(arch_pc);
         alloc(0, 1, 1, 1, 0);
         chk(int'(arch_pc) == pc0, "R10", "pc after refused alloc", int'(arch_pc), pc0);
      end
      drain("R2", 0, 0);
      rd_addr = '0; cyc();
      chk(int'(rd_data) == 0, "R12", "register 0", int'(rd_data), 0);
      sweep("R12", 0);

      // allocation offered with the drain request and held through the drain (R1)
      alloc(3, 4, 4, 2, 0);
      begin
         int pc1;
         pc1 = int'(arch_pc);
         alloc_valid = 1'b1; alloc_op = 2'd0; alloc_rd = 3'd3; alloc_rs1 = 3'd3; alloc_rs2 = 3'd3;
         drain("R1", 0, 0);
         alloc_valid = 1'b0;
         chk(int'(arch_pc) == pc1, "R1", "pc with alloc during drain", int'(arch_pc), pc1);
      end
      sweep("R3", 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule